// File: doc/BRIEF.md
# Key Store Slot Controller

This block manages a small on-chip key memory organised as eight 128-bit slots. Software first programs a key length and then selects a starting slot. That selection arms the store to take key words from a DMA word stream. The controller places each word into the memory, pads 192-bit keys up to a full slot pair, and marks the slots valid only when a complete, correctly sized key has arrived. It keeps a validity map of all slots. A clear mask lets software free slots before they are reused.

A read starts as soon as a slot is selected for reading. The controller then streams the stored key, word by word, toward the cipher engine. It refuses any write that would overwrite a valid slot, and any read of an empty slot. Misaligned two-slot selections are refused as well. Each operation ends with a done flag and, if something went wrong, an error flag.

Both word streams use valid/ready handshakes. On the inbound stream, `in_ready` is high exactly while a write is armed, and no beat is taken at any other time. On the outbound stream, the block holds `out_valid`, `out_data` and `out_last` steady while the consumer keeps `out_ready` low.

Top module: `keystore_ctrl`

## Requirements
- R1: After reset, the validity map is all zero. `wr_done`, `wr_err`, `rd_done`, `rd_err`, `in_ready` and `out_valid` are all low, and the key length is 128 bits.
- R2: Key length code 0 (128 bits) covers one slot of four 32-bit words. If exactly four beats arrive, with `in_last` on the fourth, the selected slot becomes valid, `wr_done` rises and `wr_err` stays low. Word i of the key is stored at word i of the slot.
- R3: Key length code 2 (256 bits) covers two slots, which must start on an even slot index. Eight beats are needed, and both slots become valid together.
- R4: Key length code 1 (192 bits) also takes eight beats into an even-aligned slot pair. Words 6 and 7 are stored as zero whatever data arrives, so a read returns zero for them.
- R5: If `in_last` arrives before the required number of beats, `wr_done` and `wr_err` are raised and no slot is marked valid.
- R6: Beats beyond the required count are dropped without touching memory. When `in_last` ends such a transfer, `wr_err` is raised and no slot is marked valid. Any neighbouring slot keeps its content.
- R7: A write selection that covers an already valid slot, or a two-slot selection on an odd slot, is refused. `wr_done` and `wr_err` rise one cycle later, and `in_ready` stays low.
- R8: A cycle with `clr_we` high clears every validity bit set in `clr_mask`. A clear beats a write completion in the same cycle.
- R9: A read streams the key words in order: four words for code 0, eight for codes 1 and 2. `out_last` is high on the final word only. While `out_ready` is low, the current word and `out_last` are held, and `rd_done` rises after the final handshake.
- R10: A read selection that covers a slot that is not valid, or a two-slot selection on an odd slot, raises `rd_done` and `rd_err` one cycle later. No word is streamed.
- R11: Starting a new write clears `wr_done` and `wr_err`. Starting a new read clears `rd_done` and `rd_err`.
- R12: `in_ready` is high only while a write is armed, and a key length code of 3 is ignored, so the previous length stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size_we | input | 1 | Load key length code |
| cfg_size | input | 2 | Key length code: 0=128, 1=192, 2=256 bits |
| wr_arm | input | 1 | Start a key write at `wr_slot` |
| wr_slot | input | 3 | First slot of the write |
| in_valid | input | 1 | Inbound key word valid |
| in_ready | output | 1 | Inbound key word accepted |
| in_data | input | 32 | Inbound key word |
| in_last | input | 1 | Last word of the inbound transfer |
| clr_we | input | 1 | Apply slot clear mask |
| clr_mask | input | 8 | Slots to mark invalid |
| rd_arm | input | 1 | Start a key read at `rd_slot` |
| rd_slot | input | 3 | First slot of the read |
| out_valid | output | 1 | Outbound key word valid |
| out_ready | input | 1 | Cipher engine takes the word |
| out_data | output | 32 | Outbound key word |
| out_last | output | 1 | Final outbound word |
| valid_slots | output | 8 | Slot validity map |
| wr_done | output | 1 | Write finished or refused |
| wr_err | output | 1 | Write error |
| rd_done | output | 1 | Read finished or refused |
| rd_err | output | 1 | Read error |

## Verification
The hardest case to reach is an overrun that must leave a neighbouring slot unharmed. That needs a valid key already sitting in the slot just above the target. So the stimulus first stores a 192-bit key in slots 0 and 1, then clears only slot 0. It then pushes five words at slot 0 under a 128-bit length. Finally it reads slot 1 and compares the result against the original key half and its zero padding. Refusals and read errors are forced by selecting occupied, empty or odd-aligned slots and watching the flags and both streams.

// File: rtl/ks_pkg.sv
package ks_pkg;
  typedef enum logic [1:0] {
    KS_128 = 2'd0,
    KS_192 = 2'd1,
    KS_256 = 2'd2
  } ks_size_e;
endpackage

// File: rtl/ks_span.sv
// Works out which slots a selection covers and whether its alignment is legal.
module ks_span
  import ks_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int AW = $clog2(SLOTS)
) (
  input  logic [AW-1:0]    slot,
  input  ks_size_e         size,
  output logic [SLOTS-1:0] mask,
  output logic             pair,
  output logic             misaligned
);
  logic [AW:0] next_slot;

  always_comb begin
    pair       = (size != KS_128);
    next_slot  = {1'b0, slot} + {{AW{1'b0}}, 1'b1};
    mask       = SLOTS'(1) << slot;
    if (pair) mask = mask | (SLOTS'(1) << next_slot);
    misaligned = pair & slot[0];
  end
endmodule

// File: rtl/ks_ram.sv
module ks_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ks_wr_ctl.sv
module ks_wr_ctl
  import ks_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int WORD_W = 32,
  parameter int WPS    = 4,
  localparam int SAW     = $clog2(SLOTS),
  localparam int WAW     = $clog2(SLOTS * WPS),
  localparam int CNT_W   = $clog2(2 * WPS) + 1,
  localparam int PAD_IDX = 192 / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [SAW-1:0]    arm_slot,
  input  ks_size_e          size,
  input  logic [SLOTS-1:0]  valid_map,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              ram_we,
  output logic [WAW-1:0]    ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic [SLOTS-1:0]  set_mask,
  output logic              done,
  output logic              err
);
  logic [SLOTS-1:0] span_mask, tmask_q;
  logic             span_pair, span_mis, refuse;
  logic             armed_q, ovf_q, pad_q;
  logic [WAW-1:0]   base_q;
  logic [CNT_W-1:0] need_q, cnt_q;
  logic             beat, room, bad;

  ks_span #(.SLOTS(SLOTS)) u_span (
    .slot(arm_slot), .size(size), .mask(span_mask),
    .pair(span_pair), .misaligned(span_mis)
  );

  assign refuse   = span_mis | (|(span_mask & valid_map));
  assign in_ready = armed_q;
  assign beat     = armed_q & in_valid;
  assign room     = cnt_q < need_q;
  assign bad      = ovf_q | ~room | ((cnt_q + CNT_W'(1)) != need_q);

  assign ram_we    = beat & room;
  assign ram_addr  = base_q + WAW'(cnt_q);
  assign ram_wdata = (pad_q && cnt_q >= CNT_W'(PAD_IDX)) ? '0 : in_data;
  assign set_mask  = (beat && in_last && !bad) ? tmask_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ovf_q   <= 1'b0;
      pad_q   <= 1'b0;
      base_q  <= '0;
      need_q  <= '0;
      cnt_q   <= '0;
      tmask_q <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else if (arm && !armed_q) begin
      if (refuse) begin
        done <= 1'b1;
        err  <= 1'b1;
      end else begin
        armed_q <= 1'b1;
        done    <= 1'b0;
        err     <= 1'b0;
        ovf_q   <= 1'b0;
        cnt_q   <= '0;
        pad_q   <= (size == KS_192);
        base_q  <= WAW'(WAW'(arm_slot) * WAW'(WPS));
        need_q  <= span_pair ? CNT_W'(2 * WPS) : CNT_W'(WPS);
        tmask_q <= span_mask;
      end
    end else if (beat) begin
      if (room) cnt_q <= cnt_q + CNT_W'(1);
      else      ovf_q <= 1'b1;
      if (in_last) begin
        armed_q <= 1'b0;
        done    <= 1'b1;
        err     <= bad;
      end
    end
  end
endmodule

// File: rtl/ks_rd_ctl.sv
module ks_rd_ctl
  import ks_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int WORD_W = 32,
  parameter int WPS    = 4,
  localparam int SAW   = $clog2(SLOTS),
  localparam int WAW   = $clog2(SLOTS * WPS),
  localparam int CNT_W = $clog2(2 * WPS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [SAW-1:0]    arm_slot,
  input  ks_size_e          size,
  input  logic [SLOTS-1:0]  valid_map,
  output logic [WAW-1:0]    ram_addr,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              done,
  output logic              err
);
  logic [SLOTS-1:0] span_mask;
  logic             span_pair, span_mis, refuse;
  logic             busy_q;
  logic [WAW-1:0]   base_q;
  logic [CNT_W-1:0] need_q, cnt_q;

  ks_span #(.SLOTS(SLOTS)) u_span (
    .slot(arm_slot), .size(size), .mask(span_mask),
    .pair(span_pair), .misaligned(span_mis)
  );

  assign refuse    = span_mis | (|(span_mask & ~valid_map));
  assign ram_addr  = base_q + WAW'(cnt_q);
  assign out_valid = busy_q;
  assign out_data  = ram_rdata;
  assign out_last  = busy_q && (cnt_q == need_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      need_q <= '0;
      cnt_q  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else if (arm && !busy_q) begin
      if (refuse) begin
        done <= 1'b1;
        err  <= 1'b1;
      end else begin
        busy_q <= 1'b1;
        done   <= 1'b0;
        err    <= 1'b0;
        cnt_q  <= '0;
        base_q <= WAW'(WAW'(arm_slot) * WAW'(WPS));
        need_q <= span_pair ? CNT_W'(2 * WPS) : CNT_W'(WPS);
      end
    end else if (busy_q && out_ready) begin
      if (out_last) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/keystore_ctrl.sv
module keystore_ctrl
  import ks_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 128,
  parameter int WORD_W    = 32,
  localparam int WPS = SLOT_BITS / WORD_W,
  localparam int SAW = $clog2(SLOTS),
  localparam int WAW = $clog2(SLOTS * WPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_size_we,
  input  logic [1:0]        cfg_size,
  input  logic              wr_arm,
  input  logic [SAW-1:0]    wr_slot,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic              clr_we,
  input  logic [SLOTS-1:0]  clr_mask,
  input  logic              rd_arm,
  input  logic [SAW-1:0]    rd_slot,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic [SLOTS-1:0]  valid_slots,
  output logic              wr_done,
  output logic              wr_err,
  output logic              rd_done,
  output logic              rd_err
);
  ks_size_e          size_q;
  logic [SLOTS-1:0]  valid_q, set_mask, clr_eff;
  logic              ram_we;
  logic [WAW-1:0]    ram_waddr, ram_raddr;
  logic [WORD_W-1:0] ram_wdata, ram_rdata;

  assign clr_eff     = clr_we ? clr_mask : '0;
  assign valid_slots = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= KS_128;
      valid_q <= '0;
    end else begin
      if (cfg_size_we && cfg_size != 2'd3) size_q <= ks_size_e'(cfg_size);
      valid_q <= (valid_q | set_mask) & ~clr_eff;
    end
  end

  ks_wr_ctl #(.SLOTS(SLOTS), .WORD_W(WORD_W), .WPS(WPS)) u_wr (
    .clk(clk), .rst_n(rst_n), .arm(wr_arm), .arm_slot(wr_slot),
    .size(size_q), .valid_map(valid_q),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .ram_we(ram_we), .ram_addr(ram_waddr),
    .ram_wdata(ram_wdata), .set_mask(set_mask), .done(wr_done), .err(wr_err)
  );

  ks_rd_ctl #(.SLOTS(SLOTS), .WORD_W(WORD_W), .WPS(WPS)) u_rd (
    .clk(clk), .rst_n(rst_n), .arm(rd_arm), .arm_slot(rd_slot),
    .size(size_q), .valid_map(valid_q),
    .ram_addr(ram_raddr), .ram_rdata(ram_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(rd_done), .err(rd_err)
  );

  ks_ram #(.DEPTH(SLOTS * WPS), .W(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: rtl/keystore_ctrl_sva.sv
module keystore_ctrl_sva #(
  parameter int SLOTS  = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              clr_we,
  input logic [SLOTS-1:0]  clr_mask,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_last,
  input logic [SLOTS-1:0]  valid_slots,
  input logic              wr_done,
  input logic              wr_err,
  input logic              rd_done,
  input logic              rd_err
);
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_wr_err_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> wr_done);

  assert_rd_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_done && !out_valid);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (valid_slots & $past(clr_mask)) == '0);

  assert_armed_fresh_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !wr_done && !wr_err);
endmodule

bind keystore_ctrl keystore_ctrl_sva #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .clr_we(clr_we),
  .clr_mask(clr_mask), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .valid_slots(valid_slots),
  .wr_done(wr_done), .wr_err(wr_err), .rd_done(rd_done), .rd_err(rd_err)
);

// File: tb/keystore_ctrl_bench.sv
`timescale 1ns/1ps
module keystore_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_size_we = 0;
  logic [1:0]  cfg_size = 0;
  logic        wr_arm = 0;
  logic [2:0]  wr_slot = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_data = 0;
  logic        in_last = 0;
  logic        clr_we = 0;
  logic [7:0]  clr_mask = 0;
  logic        rd_arm = 0;
  logic [2:0]  rd_slot = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [31:0] out_data;
  logic        out_last;
  logic [7:0]  valid_slots;
  logic        wr_done, wr_err, rd_done, rd_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  keystore_ctrl u_keystore_ctrl (.*);

  function automatic logic [31:0] pat(input int seed, input int i);
    return 32'hC0DE0000 + 32'(seed * 256) + 32'(i) + 32'h11000000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_size(input logic [1:0] code);
    @(negedge clk); cfg_size_we = 1; cfg_size = code;
    @(negedge clk); cfg_size_we = 0;
  endtask

  task automatic clear(input logic [7:0] m);
    @(negedge clk); clr_we = 1; clr_mask = m;
    @(negedge clk); clr_we = 0; clr_mask = 0;
  endtask

  task automatic arm_wr(input logic [2:0] s);
    @(negedge clk); wr_arm = 1; wr_slot = s;
    @(negedge clk); wr_arm = 0;
  endtask

  task automatic send(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = pat(seed, i); in_last = (i == n - 1);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    #1;
  endtask

  task automatic arm_rd(input logic [2:0] s);
    @(negedge clk); rd_arm = 1; rd_slot = s;
    @(negedge clk); rd_arm = 0;
  endtask

  // reads n words; expected word k = pat(seed, first+k), zero where pad and index >= 6
  task automatic read_check(input logic [2:0] s, input int n, input int seed,
                            input int first, input bit pad, input bit stall,
                            input string tag);
    int got = 0;
    int cyc = 0;
    logic [31:0] e;
    arm_rd(s);
    while (got < n && cyc < 100) begin
      out_ready = !(stall && cyc < 2);
      #1;
      e = (pad && first + got >= 6) ? 32'h0 : pat(seed, first + got);
      if (out_valid && out_ready) begin
        chk(out_data == e, tag, 64'(out_data), 64'(e));
        chk(out_last == (got == n - 1), {tag, " last (R9)"}, 64'(out_last), 64'(got == n - 1));
        got++;
      end else if (stall) begin
        chk(out_valid && out_data == e, "R9 hold under stall", 64'(out_data), 64'(e));
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 0;
    #1;
    chk(got == n, {tag, " word count"}, 64'(got), 64'(n));
    chk(rd_done && !rd_err && !out_valid, {tag, " rd_done"}, {rd_done, rd_err, out_valid}, 3'b100);
  endtask

  task automatic t_reset;
    #1;
    chk(valid_slots == 0 && !wr_done && !wr_err && !rd_done && !rd_err,
        "R1 reset flags", {valid_slots, wr_done, wr_err, rd_done, rd_err}, 0);
    chk(!in_ready && !out_valid, "R1 reset streams", {in_ready, out_valid}, 0);
  endtask

  task automatic t_write128;
    arm_wr(3);
    #1 chk(in_ready, "R12 ready while armed", in_ready, 1);
    send(4, 1);
    chk(wr_done && !wr_err && valid_slots == 8'h08, "R2 128-bit write",
        {wr_done, wr_err, valid_slots}, {2'b10, 8'h08});
    chk(!in_ready, "R12 ready drops after last", in_ready, 0);
    read_check(3, 4, 1, 0, 0, 1, "R2 R9 read slot3");
  endtask

  task automatic t_write256;
    set_size(2);
    arm_wr(4);
    send(8, 2);
    chk(wr_done && !wr_err && valid_slots == 8'h38, "R3 256-bit write",
        {wr_done, wr_err, valid_slots}, {2'b10, 8'h38});
    read_check(4, 8, 2, 0, 0, 0, "R3 read slots4-5");
  endtask

  task automatic t_pad192;
    set_size(1);
    arm_wr(0);
    send(8, 3);
    chk(wr_done && !wr_err && valid_slots == 8'h3B, "R4 192-bit write",
        {wr_done, wr_err, valid_slots}, {2'b10, 8'h3B});
    read_check(0, 8, 3, 0, 1, 0, "R4 padded read");
  endtask

  task automatic t_short;
    set_size(0);
    arm_wr(6);
    send(3, 4);
    chk(wr_done && wr_err && valid_slots == 8'h3B, "R5 short transfer",
        {wr_done, wr_err, valid_slots}, {2'b11, 8'h3B});
  endtask

  task automatic t_overrun;
    clear(8'h01);
    #1 chk(valid_slots == 8'h3A, "R8 clear slot0", valid_slots, 8'h3A);
    arm_wr(0);
    #1 chk(!wr_done && !wr_err, "R11 write arm clears flags", {wr_done, wr_err}, 0);
    send(5, 5);
    chk(wr_done && wr_err && valid_slots == 8'h3A, "R6 overrun",
        {wr_done, wr_err, valid_slots}, {2'b11, 8'h3A});
    read_check(1, 4, 3, 4, 1, 0, "R6 neighbour intact");
  endtask

  task automatic t_refuse;
    arm_wr(3);
    #1 chk(wr_done && wr_err && !in_ready, "R7 occupied refused",
           {wr_done, wr_err, in_ready}, 3'b110);
    set_size(2);
    arm_wr(7);
    #1 chk(wr_done && wr_err && !in_ready, "R7 odd pair refused",
           {wr_done, wr_err, in_ready}, 3'b110);
    chk(valid_slots == 8'h3A, "R7 map unchanged", valid_slots, 8'h3A);
  endtask

  task automatic t_rd_err;
    set_size(0);
    arm_rd(7);
    #1 chk(rd_done && rd_err && !out_valid, "R10 empty slot read",
           {rd_done, rd_err, out_valid}, 3'b110);
    set_size(2);
    arm_rd(5);
    #1 chk(rd_done && rd_err && !out_valid, "R10 odd pair read",
           {rd_done, rd_err, out_valid}, 3'b110);
    set_size(0);
    arm_rd(3);
    #1 chk(!rd_done && !rd_err && out_valid, "R11 read arm clears flags",
           {rd_done, rd_err, out_valid}, 3'b001);
    out_ready = 1;
    repeat (4) @(negedge clk);
    out_ready = 0;
  endtask

  task automatic t_ignore;
    @(negedge clk); in_valid = 1; in_data = 32'hDEAD; in_last = 1;
    #1 chk(!in_ready, "R12 no ready when idle", in_ready, 0);
    @(negedge clk); in_valid = 0; in_last = 0;
    #1 chk(!wr_done || wr_err, "R12 idle beat no completion", valid_slots, 8'h3A);
    chk(valid_slots == 8'h3A, "R12 idle beat no effect", valid_slots, 8'h3A);
    set_size(3);
    arm_wr(7);
    send(4, 6);
    chk(wr_done && !wr_err && valid_slots == 8'hBA, "R12 code 3 ignored",
        {wr_done, wr_err, valid_slots}, {2'b10, 8'hBA});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write128();
    t_write256();
    t_pad192();
    t_short();
    t_overrun();
    t_refuse();
    t_rd_err();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule